// File: doc/BRIEF.md
# Bus Segment Request Router

This block steers configuration, memory and I/O requests on a single bus segment. Software fills three small tables through a programming port. The first table registers device/functions, and each one owns a 4 KB configuration window. The second table holds memory and I/O windows, each with a base, a size and a target port. The third table lists the downstream bridges, each with its secondary and subordinate bus numbers.

Each request carries a space code, an address and a requester ID. The block decides where the request goes: a local target port, the upstream bridge, a downstream bridge, or a completer-abort status. For configuration requests it also picks Type 0 or Type 1, and for local configuration targets it reduces the address to the register offset.

The control is a two-state machine. In `ST_IDLE` no result is being presented. The transition *accept* moves to `ST_ROUTE` in any cycle with `req_valid` high, and it registers the decision. `ST_ROUTE` stays in `ST_ROUTE` (*chain*) while further requests arrive back to back. It returns to `ST_IDLE` (*drain*) when none arrives. `rt_valid` is high exactly while the machine is in `ST_ROUTE`. Programming is acknowledged one cycle later on `prog_done`, independently of routing.

Top module: `seg_router`

## Requirements
- R1: A function-registration operation (`prog_op`=0) installs the pair `prog_devfn` (device in bits [7:3], function in [2:0]). The resulting window is at offset (device<<15)|(function<<12) within the segment. Registering a pair that is already present is rejected (`prog_ok`=0).
- R2: A memory (`prog_op`=1) or I/O (`prog_op`=2) mapping covers `prog_base` through `prog_base+prog_size-1`. It is rejected if it overlaps a window already in the same space, or if all NWIN slots of that space are taken. Windows in different spaces never conflict.
- R3: A memory or I/O mapping with `prog_size`=0 is accepted and installs nothing.
- R4: A configuration request (`req_space`=0) whose bus field `req_addr[27:20]` differs from `seg_bus` goes to a downstream bridge (`rt_dest`=2). The bridge chosen is the earliest-registered one (`prog_op`=3, bounds `prog_sec`/`prog_sub`) with secondary ≤ bus ≤ subordinate. Such a request is Type 1 (`rt_type1`=1) with the address unchanged. If no bridge matches, the request aborts.
- R5: A configuration request for `seg_bus` that hits a registered device/function goes local (`rt_dest`=0) on that function's port, as Type 0. Its address is the request address minus the segment bus base and minus the function base, which leaves the 12-bit register offset.
- R6: A memory or I/O request outside every window, or a local-bus configuration request to an unregistered pair, goes upstream (`rt_dest`=1) as Type 0 with the address unchanged and port 0. If `req_id` equals `up_req_id`, it aborts instead (`rt_dest`=3).
- R7: Space code 3 always aborts. Every abort reports port 0, address 0 and Type 0.
- R8: `rt_valid` is high in the cycle after each cycle with `req_valid` high, including back-to-back requests, and is low otherwise. The result fields hold between requests.
- R9: `prog_done` pulses one cycle after each `prog_valid` cycle, with `prog_ok` giving the outcome. An installed window affects every request issued after that pulse.
- R10: After reset all tables are empty, and `rt_valid` and `prog_done` are low, so every memory request routes upstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_bus | input | 8 | This segment's bus number |
| up_req_id | input | 16 | Requester ID of the upstream bridge |
| prog_valid | input | 1 | Programming operation strobe |
| prog_op | input | 2 | 0 function, 1 memory window, 2 I/O window, 3 downstream bridge |
| prog_devfn | input | 8 | Device [7:3] and function [2:0] for op 0 |
| prog_base | input | AW | Window base for ops 1 and 2 |
| prog_size | input | AW | Window size for ops 1 and 2 |
| prog_sec | input | 8 | Bridge secondary bus for op 3 |
| prog_sub | input | 8 | Bridge subordinate bus for op 3 |
| prog_port | input | PW | Target port for the new entry |
| prog_done | output | 1 | Programming acknowledge pulse |
| prog_ok | output | 1 | Programming operation accepted |
| req_valid | input | 1 | Request strobe |
| req_space | input | 2 | 0 config, 1 memory, 2 I/O, 3 reserved |
| req_addr | input | AW | Request address |
| req_id | input | 16 | Requester ID |
| rt_valid | output | 1 | Route decision pulse |
| rt_dest | output | 2 | 0 local, 1 upstream, 2 downstream, 3 abort |
| rt_port | output | PW | Chosen local or bridge port |
| rt_type1 | output | 1 | Configuration request issued as Type 1 |
| rt_addr | output | AW | Forwarded address or configuration offset |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 4-bit ports, eight windows per space and four bridge slots. With eight slots, memory-table exhaustion takes only a few programming steps, so the full-table rejection is exercised next to the overlap and duplicate rejections. Two bridges with overlapping bus ranges make the earliest-registered priority visible. Windows are probed at their last address and one past it.

// File: rtl/router_pkg.sv
package router_pkg;
    typedef enum logic [1:0] {SP_CFG = 2'd0, SP_MEM = 2'd1, SP_IO = 2'd2, SP_RSVD = 2'd3} space_e;
    typedef enum logic [1:0] {DST_LOCAL = 2'd0, DST_UP = 2'd1, DST_DOWN = 2'd2, DST_ABORT = 2'd3} dest_e;
    typedef enum logic [1:0] {OP_FUNC = 2'd0, OP_MEM = 2'd1, OP_IO = 2'd2, OP_BRIDGE = 2'd3} op_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_ROUTE = 1'b1} rstate_e;
    localparam int BUS_LSB   = 20;
    localparam int DEV_SHIFT = 15;
    localparam int FN_SHIFT  = 12;
    localparam int DEVFN_W   = 8;
    localparam int BUS_W     = 8;
endpackage

// File: rtl/rt_win_table.sv
module rt_win_table #(
    parameter int NW = 8,
    parameter int AW = 32,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_base,
    input  logic [AW-1:0] wr_last,
    input  logic [PW-1:0] wr_port,
    output logic          wr_ok,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [PW-1:0] lk_port
);
    localparam int IW = (NW > 1) ? $clog2(NW) : 1;

    logic [NW-1:0] vld;
    logic [AW-1:0] lo [NW];
    logic [AW-1:0] hi [NW];
    logic [PW-1:0] prt [NW];
    logic [NW-1:0] clash, hit;
    logic          free_any;
    logic [IW-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        lk_port  = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            clash[i] = vld[i] && (wr_base <= hi[i]) && (wr_last >= lo[i]);
            hit[i]   = vld[i] && (lk_addr >= lo[i]) && (lk_addr <= hi[i]);
            if (!vld[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
        for (int i = 0; i < NW; i++)
            if (hit[i]) lk_port = lk_port | prt[i];
        lk_hit = |hit;
        wr_ok  = free_any && !(|clash);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld <= '0;
        else if (wr_en && wr_ok) vld[free_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_ok) begin
            lo[free_idx]  <= wr_base;
            hi[free_idx]  <= wr_last;
            prt[free_idx] <= wr_port;
        end
    end

    // R2
    single_window_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
    // R2
    reject_keeps_windows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |=> $stable(vld));
endmodule

// File: rtl/rt_fn_table.sv
module rt_fn_table #(
    parameter int NF = 8,
    parameter int KW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [KW-1:0] wr_key,
    input  logic [PW-1:0] wr_port,
    output logic          wr_ok,
    input  logic [KW-1:0] lk_key,
    output logic          lk_hit,
    output logic [PW-1:0] lk_port
);
    localparam int IW = (NF > 1) ? $clog2(NF) : 1;

    logic [NF-1:0] vld;
    logic [KW-1:0] key [NF];
    logic [PW-1:0] prt [NF];
    logic [NF-1:0] dup, hit;
    logic          free_any;
    logic [IW-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        lk_port  = '0;
        for (int i = NF - 1; i >= 0; i--) begin
            dup[i] = vld[i] && (key[i] == wr_key);
            hit[i] = vld[i] && (key[i] == lk_key);
            if (!vld[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
        for (int i = 0; i < NF; i++)
            if (hit[i]) lk_port = lk_port | prt[i];
        lk_hit = |hit;
        wr_ok  = free_any && !(|dup);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld <= '0;
        else if (wr_en && wr_ok) vld[free_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_ok) begin
            key[free_idx] <= wr_key;
            prt[free_idx] <= wr_port;
        end
    end

    // R1
    unique_function_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/rt_br_table.sv
module rt_br_table #(
    parameter int NB = 4,
    parameter int BW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_sec,
    input  logic [BW-1:0] wr_sub,
    input  logic [PW-1:0] wr_port,
    output logic          wr_ok,
    input  logic [BW-1:0] lk_bus,
    output logic          lk_hit,
    output logic [PW-1:0] lk_port
);
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [NB-1:0] vld;
    logic [BW-1:0] sec [NB];
    logic [BW-1:0] sub [NB];
    logic [PW-1:0] prt [NB];
    logic [NB-1:0] match;
    logic          free_any;
    logic [IW-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        lk_port  = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            match[i] = vld[i] && (sec[i] <= lk_bus) && (lk_bus <= sub[i]);
            if (match[i]) lk_port = prt[i];
            if (!vld[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
        lk_hit = |match;
        wr_ok  = free_any && (wr_sec <= wr_sub);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld <= '0;
        else if (wr_en && wr_ok) vld[free_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_ok) begin
            sec[free_idx] <= wr_sec;
            sub[free_idx] <= wr_sub;
            prt[free_idx] <= wr_port;
        end
    end
endmodule

// File: rtl/seg_router.sv
module seg_router
    import router_pkg::*;
#(
    parameter int AW   = 32,
    parameter int PW   = 4,
    parameter int NWIN = 8,
    parameter int NBR  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    seg_bus,
    input  logic [15:0]   up_req_id,
    input  logic          prog_valid,
    input  logic [1:0]    prog_op,
    input  logic [7:0]    prog_devfn,
    input  logic [AW-1:0] prog_base,
    input  logic [AW-1:0] prog_size,
    input  logic [7:0]    prog_sec,
    input  logic [7:0]    prog_sub,
    input  logic [PW-1:0] prog_port,
    output logic          prog_done,
    output logic          prog_ok,
    input  logic          req_valid,
    input  logic [1:0]    req_space,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_id,
    output logic          rt_valid,
    output logic [1:0]    rt_dest,
    output logic [PW-1:0] rt_port,
    output logic          rt_type1,
    output logic [AW-1:0] rt_addr
);
    // programming side
    logic [AW:0]   span_sum;
    logic [AW-1:0] span_last;
    logic          span_ok, size_zero;
    logic          fn_we, mem_we, io_we, br_we;
    logic          fn_wok, mem_wok, io_wok, br_wok, ok_d;

    assign span_sum  = {1'b0, prog_base} + {1'b0, prog_size};
    assign span_last = prog_base + prog_size - AW'(1);
    assign span_ok   = !(span_sum[AW] && (|span_sum[AW-1:0]));
    assign size_zero = (prog_size == '0);
    assign fn_we     = prog_valid && (op_e'(prog_op) == OP_FUNC);
    assign mem_we    = prog_valid && (op_e'(prog_op) == OP_MEM) && !size_zero && span_ok;
    assign io_we     = prog_valid && (op_e'(prog_op) == OP_IO) && !size_zero && span_ok;
    assign br_we     = prog_valid && (op_e'(prog_op) == OP_BRIDGE);

    // lookup side
    logic          fn_hit, mem_hit, io_hit, br_hit;
    logic [PW-1:0] fn_port, mem_port, io_port, br_port;
    logic [BUS_W-1:0]   req_bus;
    logic [DEVFN_W-1:0] req_devfn;

    assign req_bus   = req_addr[BUS_LSB +: BUS_W];
    assign req_devfn = req_addr[FN_SHIFT +: DEVFN_W];

    rt_fn_table #(.NF(NWIN), .KW(DEVFN_W), .PW(PW)) fn_tbl_i (
        .clk, .rst_n, .wr_en(fn_we), .wr_key(prog_devfn), .wr_port(prog_port), .wr_ok(fn_wok),
        .lk_key(req_devfn), .lk_hit(fn_hit), .lk_port(fn_port));

    rt_win_table #(.NW(NWIN), .AW(AW), .PW(PW)) mem_tbl_i (
        .clk, .rst_n, .wr_en(mem_we), .wr_base(prog_base), .wr_last(span_last), .wr_port(prog_port),
        .wr_ok(mem_wok), .lk_addr(req_addr), .lk_hit(mem_hit), .lk_port(mem_port));

    rt_win_table #(.NW(NWIN), .AW(AW), .PW(PW)) io_tbl_i (
        .clk, .rst_n, .wr_en(io_we), .wr_base(prog_base), .wr_last(span_last), .wr_port(prog_port),
        .wr_ok(io_wok), .lk_addr(req_addr), .lk_hit(io_hit), .lk_port(io_port));

    rt_br_table #(.NB(NBR), .BW(BUS_W), .PW(PW)) br_tbl_i (
        .clk, .rst_n, .wr_en(br_we), .wr_sec(prog_sec), .wr_sub(prog_sub), .wr_port(prog_port),
        .wr_ok(br_wok), .lk_bus(req_bus), .lk_hit(br_hit), .lk_port(br_port));

    always_comb begin
        unique case (op_e'(prog_op))
            OP_FUNC:   ok_d = fn_wok;
            OP_MEM:    ok_d = size_zero || (span_ok && mem_wok);
            OP_IO:     ok_d = size_zero || (span_ok && io_wok);
            OP_BRIDGE: ok_d = br_wok;
            default:   ok_d = 1'b0;
        endcase
    end

    // route decision
    dest_e         dst_d;
    logic [PW-1:0] port_d;
    logic          t1_d;
    logic [AW-1:0] addr_d;
    logic          from_up;

    assign from_up = (req_id == up_req_id);

    always_comb begin
        dst_d  = from_up ? DST_ABORT : DST_UP;
        port_d = '0;
        t1_d   = 1'b0;
        addr_d = from_up ? '0 : req_addr;
        unique case (space_e'(req_space))
            SP_CFG: begin
                if (req_bus != seg_bus) begin
                    dst_d  = br_hit ? DST_DOWN : DST_ABORT;
                    port_d = br_hit ? br_port : '0;
                    t1_d   = br_hit;
                    addr_d = br_hit ? req_addr : '0;
                end else if (fn_hit) begin
                    dst_d  = DST_LOCAL;
                    port_d = fn_port;
                    addr_d = req_addr - (AW'(seg_bus) << BUS_LSB) - (AW'(req_devfn) << FN_SHIFT);
                end
            end
            SP_MEM: if (mem_hit) begin
                dst_d  = DST_LOCAL;
                port_d = mem_port;
                addr_d = req_addr;
            end
            SP_IO: if (io_hit) begin
                dst_d  = DST_LOCAL;
                port_d = io_port;
                addr_d = req_addr;
            end
            default: begin
                dst_d  = DST_ABORT;
                addr_d = '0;
            end
        endcase
    end

    // state register
    rstate_e state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= req_valid ? ST_ROUTE : ST_IDLE;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt_dest   <= '0;
            rt_port   <= '0;
            rt_type1  <= 1'b0;
            rt_addr   <= '0;
            prog_done <= 1'b0;
            prog_ok   <= 1'b0;
        end else begin
            prog_done <= prog_valid;
            if (prog_valid) prog_ok <= ok_d;
            if (req_valid) begin
                rt_dest  <= dst_d;
                rt_port  <= port_d;
                rt_type1 <= t1_d;
                rt_addr  <= addr_d;
            end
        end
    end

    assign rt_valid = (state_q == ST_ROUTE);

    // R8
    route_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rt_valid);
    // R8
    no_stray_route_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rt_valid);
    // R7
    rsvd_space_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space == 2'd3) |=> (rt_dest == 2'd3 && rt_addr == '0));
    // R6
    no_echo_upstream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_id == up_req_id) |=> (rt_dest != 2'd1));
    // R4
    foreign_bus_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space == 2'd0 && req_addr[27:20] != seg_bus)
        |=> (rt_dest == 2'd2 || rt_dest == 2'd3));
    // R9
    prog_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) prog_valid |=> prog_done);
endmodule

// File: tb/seg_router_tb_top.sv
module seg_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int PW = 4;

    typedef struct packed {
        logic        is_req;
        logic [1:0]  code;
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  port;
        logic [15:0] id;
        logic        exp_ok;
        logic [1:0]  exp_dest;
        logic [3:0]  exp_port;
        logic        exp_t1;
        logic [31:0] exp_addr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    // prog: a = base, b = size / devfn / {sec,sub}; req: code = space, a = addr
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 32'h0, 32'h08, 4'd1, 16'h0, 1'b1, 2'd0, 4'd0, 1'b0, 32'h0, 4'd1},              // R1 dev1 fn0
        '{1'b0, 2'd0, 32'h0, 32'h08, 4'd2, 16'h0, 1'b0, 2'd0, 4'd0, 1'b0, 32'h0, 4'd1},              // R1 duplicate
        '{1'b0, 2'd0, 32'h0, 32'h11, 4'd2, 16'h0, 1'b1, 2'd0, 4'd0, 1'b0, 32'h0, 4'd1},              // R1 dev2 fn1
        '{1'b0, 2'd1, 32'h1000_0000, 32'h1000, 4'd3, 16'h0, 1'b1, 2'd0, 4'd0, 1'b0, 32'h0, 4'd2},    // R2
        '{1'b0, 2'd1, 32'h1000_0800, 32'h1000, 4'd4, 16'h0, 1'b0, 2'd0, 4'd0, 1'b0, 32'h0, 4'd2},    // R2 overlap
        '{1'b0, 2'd2, 32'h1000_0800, 32'h100, 4'd5, 16'h0, 1'b1, 2'd0, 4'd0, 1'b0, 32'h0, 4'd2},     // R2 other space
        '{1'b0, 2'd1, 32'h2000_0000, 32'h0, 4'd6, 16'h0, 1'b1, 2'd0, 4'd0, 1'b0, 32'h0, 4'd3},       // R3 size zero
        '{1'b0, 2'd3, 32'h0, 32'h0609, 4'd7, 16'h0, 1'b1, 2'd0, 4'd0, 1'b0, 32'h0, 4'd4},            // R4 bridge 6..9
        '{1'b0, 2'd3, 32'h0, 32'h080C, 4'd8, 16'h0, 1'b1, 2'd0, 4'd0, 1'b0, 32'h0, 4'd4},            // R4 bridge 8..12
        '{1'b1, 2'd1, 32'h1000_0FFF, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd0, 4'd3, 1'b0, 32'h1000_0FFF, 4'd9}, // R9 R2 last byte
        '{1'b1, 2'd1, 32'h1000_1000, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd1, 4'd0, 1'b0, 32'h1000_1000, 4'd6}, // R6 one past
        '{1'b1, 2'd1, 32'h0FFF_FFFF, 32'h0, 4'd0, 16'h0100, 1'b0, 2'd3, 4'd0, 1'b0, 32'h0, 4'd6},        // R6 from upstream
        '{1'b1, 2'd1, 32'h2000_0000, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd1, 4'd0, 1'b0, 32'h2000_0000, 4'd3}, // R3 nothing installed
        '{1'b1, 2'd2, 32'h1000_0800, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd0, 4'd5, 1'b0, 32'h1000_0800, 4'd2}, // R2 io hit
        '{1'b1, 2'd2, 32'h1000_0900, 32'h0, 4'd0, 16'h0100, 1'b0, 2'd3, 4'd0, 1'b0, 32'h0, 4'd6},        // R6 io miss from up
        '{1'b1, 2'd0, 32'h0051_10AC, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd0, 4'd2, 1'b0, 32'h0000_00AC, 4'd5}, // R5
        '{1'b1, 2'd0, 32'h0050_8FFC, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd0, 4'd1, 1'b0, 32'h0000_0FFC, 4'd5}, // R5
        '{1'b1, 2'd0, 32'h0053_0000, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd1, 4'd0, 1'b0, 32'h0053_0000, 4'd6}, // R6 cfg miss
        '{1'b1, 2'd0, 32'h0053_0000, 32'h0, 4'd0, 16'h0100, 1'b0, 2'd3, 4'd0, 1'b0, 32'h0, 4'd6},        // R6 cfg miss from up
        '{1'b1, 2'd0, 32'h0080_8000, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd2, 4'd7, 1'b1, 32'h0080_8000, 4'd4}, // R4 first match
        '{1'b1, 2'd0, 32'h00C0_0000, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd2, 4'd8, 1'b1, 32'h00C0_0000, 4'd4}, // R4 second bridge
        '{1'b1, 2'd0, 32'h00D0_0000, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd3, 4'd0, 1'b0, 32'h0, 4'd4},        // R4 no bridge
        '{1'b1, 2'd0, 32'h0060_1000, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd2, 4'd7, 1'b1, 32'h0060_1000, 4'd4}, // R4 lower edge
        '{1'b1, 2'd3, 32'h1000_0000, 32'h0, 4'd0, 16'h0200, 1'b0, 2'd3, 4'd0, 1'b0, 32'h0, 4'd7}         // R7 reserved
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    seg_bus = 8'h05;
    logic [15:0]   up_req_id = 16'h0100;
    logic          prog_valid = 1'b0;
    logic [1:0]    prog_op = '0;
    logic [7:0]    prog_devfn = '0;
    logic [AW-1:0] prog_base = '0;
    logic [AW-1:0] prog_size = '0;
    logic [7:0]    prog_sec = '0;
    logic [7:0]    prog_sub = '0;
    logic [PW-1:0] prog_port = '0;
    logic          prog_done, prog_ok;
    logic          req_valid = 1'b0;
    logic [1:0]    req_space = '0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_id = '0;
    logic          rt_valid;
    logic [1:0]    rt_dest;
    logic [PW-1:0] rt_port;
    logic          rt_type1;
    logic [AW-1:0] rt_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_router #(.AW(AW), .PW(PW), .NWIN(8), .NBR(4)) dut_i (
        .clk, .rst_n, .seg_bus, .up_req_id,
        .prog_valid, .prog_op, .prog_devfn, .prog_base, .prog_size, .prog_sec, .prog_sub, .prog_port,
        .prog_done, .prog_ok,
        .req_valid, .req_space, .req_addr, .req_id,
        .rt_valid, .rt_dest, .rt_port, .rt_type1, .rt_addr);

    task automatic check_prog(input logic exp_ok, input int rq);
        checks++;
        if (prog_done !== 1'b1 || prog_ok !== exp_ok) begin
            fails++;
            $display("FAIL R%0d prog: actual done=%b ok=%b expected done=1 ok=%b", rq, prog_done, prog_ok, exp_ok);
        end
    endtask

    task automatic check_route(input vec_t v);
        checks++;
        if (rt_valid !== 1'b1 || rt_dest !== v.exp_dest || rt_port !== v.exp_port ||
            rt_type1 !== v.exp_t1 || rt_addr !== v.exp_addr) begin
            fails++;
            $display("FAIL R%0d route: actual v=%b d=%0d p=%0d t1=%b a=%h expected v=1 d=%0d p=%0d t1=%b a=%h",
                     v.rq, rt_valid, rt_dest, rt_port, rt_type1, rt_addr,
                     v.exp_dest, v.exp_port, v.exp_t1, v.exp_addr);
        end
    endtask

    task automatic drive(input vec_t v);
        if (v.is_req) begin
            req_valid = 1'b1; req_space = v.code; req_addr = v.a; req_id = v.id;
        end else begin
            prog_valid = 1'b1; prog_op = v.code; prog_base = v.a; prog_size = v.b;
            prog_devfn = v.b[7:0]; prog_sec = v.b[15:8]; prog_sub = v.b[7:0]; prog_port = v.port;
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        drive(v);
        @(negedge clk);
        req_valid = 1'b0;
        prog_valid = 1'b0;
        if (v.is_req) check_route(v);
        else          check_prog(v.exp_ok, int'(v.rq));
    endtask

    function automatic vec_t mk_req(input logic [1:0] sp, input logic [31:0] a, input logic [15:0] id,
                                    input logic [1:0] d, input logic [3:0] p, input logic t1,
                                    input logic [31:0] ea, input logic [3:0] rq);
        return '{1'b1, sp, a, 32'h0, 4'd0, id, 1'b0, d, p, t1, ea, rq};
    endfunction

    function automatic vec_t mk_prog(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                                     input logic [3:0] p, input logic ok, input logic [3:0] rq);
        return '{1'b0, op, a, b, p, 16'h0, ok, 2'd0, 4'd0, 1'b0, 32'h0, rq};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        checks++;
        if (rt_valid !== 1'b0 || prog_done !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: actual rt_valid=%b prog_done=%b expected 0 0", rt_valid, prog_done);
        end
        // R10 empty tables: memory and local config both go upstream
        apply(mk_req(2'd1, 32'h1000_0000, 16'h0200, 2'd1, 4'd0, 1'b0, 32'h1000_0000, 4'd10));
        apply(mk_req(2'd0, 32'h0050_8000, 16'h0200, 2'd1, 4'd0, 1'b0, 32'h0050_8000, 4'd10));

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R2 capacity: seven more memory windows fill the table, the ninth is refused
        for (int k = 0; k < 7; k++)
            apply(mk_prog(2'd1, 32'h3000_0000 + 32'(k) * 32'h1000, 32'h100, 4'd9, 1'b1, 4'd2));
        apply(mk_prog(2'd1, 32'h4000_0000, 32'h100, 4'd9, 1'b0, 4'd2));
        apply(mk_req(2'd1, 32'h4000_0000, 16'h0200, 2'd1, 4'd0, 1'b0, 32'h4000_0000, 4'd2));
        apply(mk_req(2'd1, 32'h3000_60FF, 16'h0200, 2'd0, 4'd9, 1'b0, 32'h3000_60FF, 4'd2));

        // R8 back-to-back requests, then idle
        @(negedge clk);
        drive(mk_req(2'd2, 32'h1000_08FF, 16'h0200, 2'd0, 4'd5, 1'b0, 32'h1000_08FF, 4'd8));
        @(negedge clk);
        check_route(mk_req(2'd2, 32'h1000_08FF, 16'h0200, 2'd0, 4'd5, 1'b0, 32'h1000_08FF, 4'd8));
        drive(mk_req(2'd3, 32'h0, 16'h0200, 2'd3, 4'd0, 1'b0, 32'h0, 4'd8));
        @(negedge clk);
        check_route(mk_req(2'd3, 32'h0, 16'h0200, 2'd3, 4'd0, 1'b0, 32'h0, 4'd8));
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (rt_valid !== 1'b0 || rt_dest !== 2'd3) begin
            fails++;
            $display("FAIL R8 idle: actual rt_valid=%b dest=%0d expected 0 3 (held)", rt_valid, rt_dest);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule